// File: doc/BRIEF.md
# Video memory address/data port

This block is the processor-side register window onto a graphics controller's private video memory. The processor never addresses video memory directly. It loads a 14-bit pointer with two byte writes to an address register, high byte first. It then moves bytes through a data register. Every data access sends a one-cycle request, which carries the pointer and the byte, to the bus sequencer behind the block, and the pointer steps forward in the same cycle. Bytes can therefore be streamed without setting the address up again.

A single first/second flag decides which half of a two-byte register a write lands in. The address register and a scroll register both use this flag and both flip it. A read of the status register forces the flag back to "first", so the next address write is taken as the high byte. A control register bit selects the pointer step: one byte, or one 32-tile row. Data accesses are accepted on any cycle. The block has no blanking input and no gating of any kind.

Top module: `vram_port`

## Requirements
- R1: A synchronous reset, active high, clears the pointer, the holding byte, the flag, the step select and both scroll bytes, and holds the request output low. A reset in mid-sequence gives the same state.
- R2: A write to select 3 with the flag at "first" (`wtoggle`=0) stores bits 5:0 of the byte as the pointer's high part and leaves `vptr` unchanged. A write to select 3 with the flag at "second" sets `vptr` to {held high part, byte}. Each such write inverts the flag.
- R3: A write to select 4 makes `vreq_valid`=1 and `vreq_write`=1 in the following cycle, with `vreq_addr` set to the pointer before the write and `vreq_data` set to the byte. In that same cycle `vptr` already shows the stepped value.
- R4: A write to select 0 latches bit 2 of the byte as the step select. With bit 2 at 0 each data access adds 1 to the pointer. With bit 2 at 1 each data access adds 32.
- R5: Pointer arithmetic wraps modulo 16384: 0x3FFF+1 gives 0x0000, and 0x3FF0+32 gives 0x0010.
- R6: A write to select 2 stores the byte in `scroll_x` when the flag is "first" and in `scroll_y` when the flag is "second", and it inverts the flag. Scroll and address writes share one flag.
- R7: A read of select 1 clears the flag to "first".
- R8: A read of select 4 makes `vreq_valid`=1 and `vreq_write`=0 in the following cycle, with the pre-step address and `vreq_data`=0, and it steps the pointer. Data accesses do not touch the flag.
- R9: Data accesses on consecutive cycles each produce their own request and step, with no cycle refused.
- R10: When read and write strobes are both high, only the write acts. Selects 5 to 7, and reads of selects 0, 2 and 3, change no state and raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 3 | Register select: 0 control, 1 status, 2 scroll, 3 address, 4 data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write byte |
| vreq_valid | output | 1 | One-cycle video memory access request |
| vreq_write | output | 1 | 1 for a write request, 0 for a read request |
| vreq_addr | output | 14 | Address of the request (pointer before the step) |
| vreq_data | output | 8 | Byte to write; 0 for a read request |
| vptr | output | 14 | Current video memory pointer |
| wtoggle | output | 1 | Shared first/second write flag |
| scroll_x | output | 8 | Byte from the first scroll write |
| scroll_y | output | 8 | Byte from the second scroll write |

## Verification
Every result of this block appears exactly one clock after the strobe that causes it: the request fields, the stepped pointer, the new flag value and the scroll bytes are all registered once. The bench drives a strobe on a falling edge and updates its behavioural model at the following rising edge. It compares every output at the next falling edge, so each comparison falls on the first cycle in which the result is due. No cycle is skipped between comparisons, so an extra or missing request pulse on any cycle is caught.

// File: rtl/vport_pkg.sv
package vport_pkg;

    localparam int VA_W   = 14;
    localparam int DW     = 8;
    localparam int SEL_W  = 3;
    localparam int HI_W   = VA_W - DW;
    localparam int STEP_BIT = 2;

    localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd0;
    localparam logic [SEL_W-1:0] SEL_STATUS = 3'd1;
    localparam logic [SEL_W-1:0] SEL_SCROLL = 3'd2;
    localparam logic [SEL_W-1:0] SEL_ADDR   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_DATA   = 3'd4;

    typedef struct packed {
        logic ctrl_wr;
        logic scroll_wr;
        logic addr_wr;
        logic data_wr;
        logic status_rd;
        logic data_rd;
    } strobe_t;

    typedef struct packed {
        logic [VA_W-1:0] ptr;
        logic [HI_W-1:0] hi;
        logic            tog;
        logic            big;
        logic [DW-1:0]   sx;
        logic [DW-1:0]   sy;
        logic            rv;
        logic            rw;
        logic [VA_W-1:0] ra;
        logic [DW-1:0]   rdat;
    } port_state_t;

endpackage

// File: rtl/vport_decode.sv
module vport_decode
    import vport_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             wr,
    input  logic             rd,
    output strobe_t          stb
);
    logic rd_only;

    always_comb begin
        rd_only       = rd && !wr;
        stb           = '0;
        stb.ctrl_wr   = wr && (sel == SEL_CTRL);
        stb.scroll_wr = wr && (sel == SEL_SCROLL);
        stb.addr_wr   = wr && (sel == SEL_ADDR);
        stb.data_wr   = wr && (sel == SEL_DATA);
        stb.status_rd = rd_only && (sel == SEL_STATUS);
        stb.data_rd   = rd_only && (sel == SEL_DATA);
    end
endmodule

// File: rtl/vport_step.sv
module vport_step #(
    parameter int ADDR_W   = 14,
    parameter int ROW_STEP = 32
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic              big,
    output logic [ADDR_W-1:0] nxt
);
    localparam logic [ADDR_W-1:0] INC_SMALL = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] INC_BIG   = ADDR_W'(ROW_STEP);

    always_comb begin
        nxt = ptr + (big ? INC_BIG : INC_SMALL);
    end
endmodule

// File: rtl/vram_port.sv
module vram_port
    import vport_pkg::*;
#(
    parameter int ROW_STEP = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DW-1:0]    bus_wdata,
    output logic             vreq_valid,
    output logic             vreq_write,
    output logic [VA_W-1:0]  vreq_addr,
    output logic [DW-1:0]    vreq_data,
    output logic [VA_W-1:0]  vptr,
    output logic             wtoggle,
    output logic [DW-1:0]    scroll_x,
    output logic [DW-1:0]    scroll_y
);
    port_state_t     st_d, st_q;
    strobe_t         stb;
    logic [VA_W-1:0] ptr_inc;

    vport_decode i_decode (
        .sel (bus_sel),
        .wr  (bus_wr),
        .rd  (bus_rd),
        .stb (stb)
    );

    vport_step #(
        .ADDR_W   (VA_W),
        .ROW_STEP (ROW_STEP)
    ) i_step (
        .ptr (st_q.ptr),
        .big (st_q.big),
        .nxt (ptr_inc)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rv   = 1'b0;
        st_d.rw   = 1'b0;
        st_d.ra   = '0;
        st_d.rdat = '0;

        if (stb.ctrl_wr) begin
            st_d.big = bus_wdata[STEP_BIT];
        end

        if (stb.scroll_wr) begin
            if (st_q.tog) st_d.sy = bus_wdata;
            else          st_d.sx = bus_wdata;
            st_d.tog = ~st_q.tog;
        end

        if (stb.addr_wr) begin
            if (st_q.tog) st_d.ptr = {st_q.hi, bus_wdata};
            else          st_d.hi  = bus_wdata[HI_W-1:0];
            st_d.tog = ~st_q.tog;
        end

        if (stb.data_wr || stb.data_rd) begin
            st_d.rv   = 1'b1;
            st_d.rw   = stb.data_wr;
            st_d.ra   = st_q.ptr;
            st_d.rdat = stb.data_wr ? bus_wdata : '0;
            st_d.ptr  = ptr_inc;
        end

        if (stb.status_rd) begin
            st_d.tog = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign vreq_valid = st_q.rv;
    assign vreq_write = st_q.rw;
    assign vreq_addr  = st_q.ra;
    assign vreq_data  = st_q.rdat;
    assign vptr       = st_q.ptr;
    assign wtoggle    = st_q.tog;
    assign scroll_x   = st_q.sx;
    assign scroll_y   = st_q.sy;

    // R1: state is cleared one edge after reset is sampled
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (vptr == '0 && !wtoggle && !vreq_valid && scroll_x == '0 && scroll_y == '0));

    // R2: second address byte lands in the low part and returns the flag to first
    assert_addr_low_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel == SEL_ADDR && wtoggle) |=>
            (vptr[DW-1:0] == $past(bus_wdata) && !wtoggle));

    // R3: a data write yields a write request with the old pointer and the byte
    assert_write_req_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel == SEL_DATA) |=>
            (vreq_valid && vreq_write && vreq_addr == $past(vptr) && vreq_data == $past(bus_wdata)));

    // R4: the pointer beside a request is the request address plus the step
    assert_step_size_R4: assert property (@(posedge clk) disable iff (rst)
        vreq_valid |-> (vptr == vreq_addr + (st_q.big ? VA_W'(ROW_STEP) : VA_W'(1))));

    // R6: scroll writes invert the shared flag
    assert_scroll_flip_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel == SEL_SCROLL) |=> (wtoggle != $past(wtoggle)));

    // R7: status read returns the flag to first
    assert_status_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_sel == SEL_STATUS) |=> !wtoggle);

    // R8: data reads leave the flag alone
    assert_read_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_sel == SEL_DATA) |=>
            (vreq_valid && !vreq_write && wtoggle == $past(wtoggle)));
endmodule

// File: tb/test_vram_port.sv
module test_vram_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_sel = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic        vreq_valid, vreq_write, wtoggle;
    logic [13:0] vreq_addr, vptr;
    logic [7:0]  vreq_data, scroll_x, scroll_y;

    vram_port i_vram_port (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .vreq_valid(vreq_valid), .vreq_write(vreq_write),
        .vreq_addr(vreq_addr), .vreq_data(vreq_data), .vptr(vptr), .wtoggle(wtoggle),
        .scroll_x(scroll_x), .scroll_y(scroll_y)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_ptr, m_hi, m_tog, m_big, m_sx, m_sy, m_rv, m_rw, m_ra, m_rd;

    task automatic model_step(input int sel, input bit wr, input bit rd, input int wd, input bit rs);
        m_rv = 0; m_rw = 0; m_ra = 0; m_rd = 0;
        if (rs) begin
            m_ptr = 0; m_hi = 0; m_tog = 0; m_big = 0; m_sx = 0; m_sy = 0;
        end else if (wr) begin
            case (sel)
                0: m_big = (wd >> 2) & 1;
                2: begin
                    if (m_tog == 0) m_sx = wd; else m_sy = wd;
                    m_tog = 1 - m_tog;
                end
                3: begin
                    if (m_tog == 0) m_hi = wd % 64; else m_ptr = m_hi * 256 + wd;
                    m_tog = 1 - m_tog;
                end
                4: begin
                    m_rv = 1; m_rw = 1; m_ra = m_ptr; m_rd = wd;
                    m_ptr = (m_ptr + (m_big ? 32 : 1)) % 16384;
                end
                default: ;
            endcase
        end else if (rd) begin
            if (sel == 1) m_tog = 0;
            if (sel == 4) begin
                m_rv = 1; m_rw = 0; m_ra = m_ptr; m_rd = 0;
                m_ptr = (m_ptr + (m_big ? 32 : 1)) % 16384;
            end
        end
    endtask

    task automatic compare();
        n_vec++;
        if (vreq_valid !== 1'(m_rv) || vreq_write !== 1'(m_rw) || vreq_addr !== 14'(m_ra) ||
            vreq_data !== 8'(m_rd) || vptr !== 14'(m_ptr) || wtoggle !== 1'(m_tog) ||
            scroll_x !== 8'(m_sx) || scroll_y !== 8'(m_sy)) begin
            n_bad++;
            $display("FAIL %s: actual v=%0b w=%0b a=%h d=%h p=%h t=%0b sx=%h sy=%h expected v=%0d w=%0d a=%h d=%h p=%h t=%0d sx=%h sy=%h",
                cur_req, vreq_valid, vreq_write, vreq_addr, vreq_data, vptr, wtoggle, scroll_x, scroll_y,
                m_rv, m_rw, m_ra, m_rd, m_ptr, m_tog, m_sx, m_sy);
        end
    endtask

    // drive on a falling edge, model at the rising edge, compare at the next falling edge
    task automatic cyc(input int sel, input bit wr, input bit rd, input int wd, input bit rs = 1'b0);
        bus_sel = 3'(sel); bus_wr = wr; bus_rd = rd; bus_wdata = 8'(wd); rst = rs;
        @(posedge clk);
        model_step(sel, wr, rd, wd, rs);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; rst = 1'b0;
        compare();
    endtask

    task automatic idle();
        cyc(0, 1'b0, 1'b0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R9: watchdog expired, actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        cur_req = "R1";
        cyc(0, 0, 0, 0, 1'b1);
        cyc(0, 0, 0, 0, 1'b1);
        idle();

        cur_req = "R2";
        cyc(3, 1, 0, 8'h21);
        cyc(3, 1, 0, 8'h00);
        cyc(3, 1, 0, 8'hC5);   // bits 7:6 dropped
        cyc(3, 1, 0, 8'h7A);

        cur_req = "R3";
        cyc(3, 1, 0, 8'h21); cyc(3, 1, 0, 8'h00);
        cyc(4, 1, 0, 8'h01);
        cyc(4, 1, 0, 8'h02);
        idle();

        cur_req = "R4";
        cyc(0, 1, 0, 8'h04);
        cyc(4, 1, 0, 8'h11);
        cyc(4, 1, 0, 8'h12);
        cyc(0, 1, 0, 8'hFB);   // bit 2 low, others high
        cyc(4, 1, 0, 8'h13);

        cur_req = "R5";
        cyc(3, 1, 0, 8'hFF); cyc(3, 1, 0, 8'hFF);
        cyc(4, 1, 0, 8'hAA);
        cyc(0, 1, 0, 8'h04);
        cyc(3, 1, 0, 8'h3F); cyc(3, 1, 0, 8'hF0);
        cyc(4, 1, 0, 8'hBB);
        cyc(0, 1, 0, 8'h00);

        cur_req = "R6";
        cyc(2, 1, 0, 8'h5C);
        cyc(2, 1, 0, 8'hE3);
        cyc(2, 1, 0, 8'h10);   // flag now second
        cyc(3, 1, 0, 8'h44);   // taken as low byte
        idle();

        cur_req = "R7";
        cyc(2, 1, 0, 8'h20);
        cyc(1, 0, 1, 0);
        cyc(3, 1, 0, 8'h12);
        cyc(1, 0, 1, 0);
        cyc(3, 1, 0, 8'h23); cyc(3, 1, 0, 8'h45);

        cur_req = "R8";
        cyc(3, 1, 0, 8'h30);   // flag second, held across reads
        cyc(4, 0, 1, 0);
        cyc(4, 0, 1, 0);
        cyc(3, 1, 0, 8'h80);

        cur_req = "R9";
        for (int i = 0; i < 40; i++) begin
            if (i == 20) cyc(0, 1, 0, 8'h04);
            else if (i % 3 == 2) cyc(4, 0, 1, 0);
            else cyc(4, 1, 0, i * 7);
        end
        cyc(0, 1, 0, 8'h00);

        cur_req = "R10";
        cyc(2, 1, 0, 8'h01);   // flag second
        cyc(4, 1, 1, 8'h66);   // write wins over read
        cyc(1, 1, 1, 8'h99);   // status read ignored: flag kept
        for (int s = 5; s < 8; s++) begin
            cyc(s, 1, 0, 8'hFF);
            cyc(s, 0, 1, 0);
        end
        cyc(0, 0, 1, 0); cyc(2, 0, 1, 0); cyc(3, 0, 1, 0);
        idle();

        cur_req = "R1";
        cyc(2, 1, 0, 8'h77);
        cyc(0, 1, 0, 8'h04);
        cyc(4, 1, 0, 8'h55, 1'b1);
        cyc(4, 1, 0, 8'h56);
        idle();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule